// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a parallel NOR-style flash bus. It takes over once the host has sent the last write pulse of a program or erase command sequence. From then on it reads the status byte at a chosen address until it can tell that the embedded operation has ended. Each read is a separate strobe: chip enable and output enable go low together for a parameterised number of cycles, and the data bus is sampled at the end of that window. Between two reads the strobes go high for at least one cycle.

Two detection methods can be selected for each operation. The first is data polling: bit 7 of the status byte is compared with a target value. The second is toggle detection: bit 6 of two back-to-back reads is compared. Near the end of an operation bit 7 can change before the lower bits are valid. For this reason, once completion is seen, the poller always makes one more read and reports that byte as the final data. The final byte is compared with the value the operation should have left behind, which flags a protected sector that was silently skipped. A programmable limit on status reads ends a run that never completes. Each run ends with a one-cycle done pulse and a two-bit status code.

The host must assert `start` only after the final write pulse: the fourth pulse of a program sequence, or the sixth of an erase. For an erase, `pollAddr` must point inside a sector that is being erased and is not protected.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is held and after it is released, `flashCeN` and `flashOeN` are 1, `busy` and `donePulse` are 0, and `status` is 0.
- R2: Every read holds `flashCeN` and `flashOeN` low together for exactly STROBE_W clock cycles, with `flashAddr` equal to the `pollAddr` captured at start. At least one cycle with both strobes high separates consecutive reads.
- R3: `start` is accepted only while `busy` is 0. A `start` given while busy is ignored: the address, operation and outcome of the run in progress are unchanged, and no second done pulse follows.
- R4: In data-polling mode (`useToggle`=0) for a program (`opErase`=0), a status read counts as complete when its bit 7 equals bit 7 of `expData`.
- R5: In data-polling mode for an erase (`opErase`=1), a status read counts as complete when its bit 7 is 1.
- R6: In toggle mode (`useToggle`=1), completion is seen when bit 6 of a status read equals bit 6 of the previous status read of the same run. The first status read of a run never counts as complete.
- R7: Once completion is seen, exactly one more read is made, and its byte is reported on `resultData`.
- R8: `status` is 0 (ok) when that final byte equals the expected value, and 1 (protected) when it does not. The expected value is `expData` for a program and 8'hFF for an erase.
- R9: If no completion is seen within max(`maxPolls`,1) status reads, no further read is made. `status` is then 2 (timeout) and `resultData` is the last status byte read.
- R10: `donePulse` is high for exactly one cycle per run, and `busy` is 0 in that cycle. `status` and `resultData` keep their values until the next run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (sampled when idle) |
| opErase | input | 1 | 1 = erase in progress, 0 = program |
| useToggle | input | 1 | 1 = toggle method on bit 6, 0 = data polling on bit 7 |
| pollAddr | input | ADDR_W | Address to poll |
| expData | input | 8 | Byte written by the program operation |
| maxPolls | input | CNT_W | Status-read limit (0 behaves as 1) |
| flashCeN | output | 1 | Chip enable, active low |
| flashOeN | output | 1 | Output enable, active low |
| flashAddr | output | ADDR_W | Flash address |
| flashDq | input | 8 | Flash data bus |
| busy | output | 1 | A run is in progress |
| donePulse | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 ok, 1 protected, 2 timeout |
| resultData | output | 8 | Final byte read |

## Verification
The hardest case to reach is a read where bit 7 (or bit 6) already shows completion while the low bits still carry garbage. This can expose a poller that reports that byte instead of re-reading. The bench flash model serves a per-run list of bytes indexed by strobe count. The list has a number of busy reads, then one lagging byte with the correct status bit but random low bits, then the settled byte. Protected-sector runs, where the settled byte is the old contents, and tight read limits are drawn at random and also placed in directed cases.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_PROT    = 2'd1,
    ST_TIMEOUT = 2'd2
  } pollStatus_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_POLL,
    S_CONFIRM
  } pollState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCmd;     // capture address, clear read counter
    logic startRead;   // launch one read strobe
    logic countRead;   // the read in flight is a status read
    logic latchResult; // copy last captured byte to result
  } dpCtrl_t;

endpackage

// File: rtl/fpoll_datapath.sv
module fpoll_datapath
  import fpoll_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int STROBE_W = 3,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        flashDq,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [7:0]        curData,
  output logic              prevDq6,
  output logic [CNT_W-1:0]  pollCnt,
  output logic              readDone,
  output logic [7:0]        resultData
);

  localparam int TMR_W = (STROBE_W > 1) ? $clog2(STROBE_W) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(STROBE_W - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;

  logic             rdActive;
  logic [TMR_W-1:0] rdTimer;
  logic [ADDR_W-1:0] addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdActive   <= 1'b0;
      rdTimer    <= '0;
      readDone   <= 1'b0;
      curData    <= '0;
      prevDq6    <= 1'b0;
      pollCnt    <= '0;
      addrReg    <= '0;
      resultData <= '0;
    end else begin
      readDone <= 1'b0;
      if (ctrl.loadCmd) begin
        addrReg <= cmdAddr;
        pollCnt <= '0;
      end
      if (ctrl.startRead && !rdActive) begin
        rdActive <= 1'b1;
        rdTimer  <= TMR_LOAD;
      end else if (rdActive) begin
        if (rdTimer == '0) begin
          rdActive <= 1'b0;
          curData  <= flashDq;
          prevDq6  <= curData[6];
          readDone <= 1'b1;
          if (ctrl.countRead && pollCnt != CNT_SAT)
            pollCnt <= pollCnt + CNT_W'(1);
        end else begin
          rdTimer <= rdTimer - TMR_W'(1);
        end
      end
      if (ctrl.latchResult)
        resultData <= curData;
    end
  end

  assign flashCeN  = !rdActive;
  assign flashOeN  = !rdActive;
  assign flashAddr = addrReg;

  // address must not move while a strobe is low
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!flashOeN && $past(!flashOeN)) |-> $stable(flashAddr));

  // the cycle after a capture has the strobes high
  assert_read_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    readDone |-> (flashOeN && flashCeN));

endmodule

// File: rtl/fpoll_control.sv
module fpoll_control
  import fpoll_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opErase,
  input  logic             useToggle,
  input  logic [7:0]       expData,
  input  logic [CNT_W-1:0] maxPolls,
  input  logic             readDone,
  input  logic [7:0]       curData,
  input  logic             prevDq6,
  input  logic [CNT_W-1:0] pollCnt,
  output dpCtrl_t          ctrl,
  output logic             busy,
  output logic             donePulse,
  output logic [1:0]       status
);

  pollState_e       state, nextState;
  pollStatus_e      statusReg, finStatus;
  logic             finish;
  logic             opReg, toggleReg;
  logic [7:0]       expReg;
  logic [CNT_W-1:0] maxReg;
  logic [CNT_W-1:0] maxEff;
  logic [7:0]       target;
  logic             hit;

  assign target = opReg ? 8'hFF : expReg;
  assign maxEff = (maxReg == '0) ? CNT_W'(1) : maxReg;
  assign hit    = toggleReg ? ((pollCnt >= CNT_W'(2)) && (curData[6] == prevDq6))
                            : (curData[7] == target[7]);

  always_comb begin
    ctrl           = '0;
    ctrl.countRead = (state == S_POLL);
    nextState      = state;
    finish         = 1'b0;
    finStatus      = ST_OK;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctrl.loadCmd   = 1'b1;
          ctrl.startRead = 1'b1;
          nextState      = S_POLL;
        end
      end
      S_POLL: begin
        if (readDone) begin
          if (hit) begin
            ctrl.startRead = 1'b1;
            nextState      = S_CONFIRM;
          end else if (pollCnt >= maxEff) begin
            ctrl.latchResult = 1'b1;
            finish           = 1'b1;
            finStatus        = ST_TIMEOUT;
            nextState        = S_IDLE;
          end else begin
            ctrl.startRead = 1'b1;
          end
        end
      end
      S_CONFIRM: begin
        if (readDone) begin
          ctrl.latchResult = 1'b1;
          finish           = 1'b1;
          finStatus        = (curData == target) ? ST_OK : ST_PROT;
          nextState        = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      statusReg <= ST_OK;
      donePulse <= 1'b0;
      opReg     <= 1'b0;
      toggleReg <= 1'b0;
      expReg    <= '0;
      maxReg    <= '0;
    end else begin
      state     <= nextState;
      donePulse <= finish;
      if (finish) statusReg <= finStatus;
      if (state == S_IDLE && start) begin
        opReg     <= opErase;
        toggleReg <= useToggle;
        expReg    <= expData;
        maxReg    <= maxPolls;
      end
    end
  end

  assign busy   = (state != S_IDLE);
  assign status = statusReg;

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(opReg) && $stable(expReg) && $stable(toggleReg)));

  assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && status == 2'd2) |-> (pollCnt >= maxEff));

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int STROBE_W = 3,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              opErase,
  input  logic              useToggle,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [7:0]        expData,
  input  logic [CNT_W-1:0]  maxPolls,
  output logic              flashCeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  input  logic [7:0]        flashDq,
  output logic              busy,
  output logic              donePulse,
  output logic [1:0]        status,
  output logic [7:0]        resultData
);

  dpCtrl_t          ctrl;
  logic [7:0]       curData;
  logic             prevDq6;
  logic [CNT_W-1:0] pollCnt;
  logic             readDone;

  fpoll_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .opErase   (opErase),
    .useToggle (useToggle),
    .expData   (expData),
    .maxPolls  (maxPolls),
    .readDone  (readDone),
    .curData   (curData),
    .prevDq6   (prevDq6),
    .pollCnt   (pollCnt),
    .ctrl      (ctrl),
    .busy      (busy),
    .donePulse (donePulse),
    .status    (status)
  );

  fpoll_datapath #(.ADDR_W(ADDR_W), .STROBE_W(STROBE_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .cmdAddr    (pollAddr),
    .flashDq    (flashDq),
    .flashCeN   (flashCeN),
    .flashOeN   (flashOeN),
    .flashAddr  (flashAddr),
    .curData    (curData),
    .prevDq6    (prevDq6),
    .pollCnt    (pollCnt),
    .readDone   (readDone),
    .resultData (resultData)
  );

endmodule

// File: tb/tb_flash_done_poller.sv
`timescale 1ns/1ps
module tb_flash_done_poller;

  localparam int ADDR_W   = 21;
  localparam int STROBE_W = 3;
  localparam int CNT_W    = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, opErase = 1'b0, useToggle = 1'b0;
  logic [ADDR_W-1:0] pollAddr = '0;
  logic [7:0] expData = '0;
  logic [CNT_W-1:0] maxPolls = '0;
  logic flashCeN, flashOeN, busy, donePulse;
  logic [ADDR_W-1:0] flashAddr;
  logic [7:0] flashDq, resultData;
  logic [1:0] status;

  always #2.5 clk = ~clk;

  flash_done_poller #(.ADDR_W(ADDR_W), .STROBE_W(STROBE_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opErase(opErase), .useToggle(useToggle),
    .pollAddr(pollAddr), .expData(expData), .maxPolls(maxPolls),
    .flashCeN(flashCeN), .flashOeN(flashOeN), .flashAddr(flashAddr), .flashDq(flashDq),
    .busy(busy), .donePulse(donePulse), .status(status), .resultData(resultData));

  int checks = 0;
  int fails  = 0;

  // flash model: byte list indexed by strobe number of the current run
  logic [7:0] seq [0:63];
  int readIdx = 0;
  int rdBase  = 0;
  always @(negedge flashOeN) readIdx++;
  always_comb begin
    int k;
    k = readIdx - rdBase;
    if (k > 63) k = 63;
    if (k < 0) k = 0;
    flashDq = seq[k];
  end

  // port monitor
  logic [ADDR_W-1:0] expAddr = '0;
  int strobeErr = 0, lowCnt = 0, doneCnt = 0, doneErr = 0;
  logic prevLow = 1'b0, prevDone = 1'b0;
  logic [1:0] lastStatus = '0;
  logic [7:0] lastResult = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!flashOeN) begin
        lowCnt++;
        if (flashCeN || flashAddr != expAddr) strobeErr++;
      end else begin
        if (flashCeN == 1'b0) strobeErr++;
        if (prevLow && lowCnt != STROBE_W) strobeErr++;
        lowCnt = 0;
      end
      prevLow = !flashOeN;
      if (donePulse) begin
        doneCnt++;
        lastStatus = status;
        lastResult = resultData;
        if (busy || prevDone) doneErr++;
      end
      prevDone = donePulse;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference outcome from the requirements
  task automatic predict(input bit tgl, input bit er, input logic [7:0] ex,
                         input int maxp, output int nReads, output int st,
                         output logic [7:0] res);
    logic [7:0] tgt;
    int m, h;
    tgt = er ? 8'hFF : ex;
    m = (maxp == 0) ? 1 : maxp;
    h = 0;
    for (int i = 1; i <= m && h == 0; i++) begin
      if (!tgl && seq[i][7] == tgt[7]) h = i;            // R4 R5
      if (tgl && i >= 2 && seq[i][6] == seq[i-1][6]) h = i; // R6
    end
    if (h != 0) begin
      nReads = h + 1;                                   // R7
      res = seq[h+1];
      st = (res == tgt) ? 0 : 1;                        // R8
    end else begin
      nReads = m;                                       // R9
      res = seq[m];
      st = 2;
    end
  endtask

  task automatic runOp(input bit tgl, input bit er, input logic [7:0] ex,
                       input int maxp, input int nBusy, input bit prot,
                       input bit inject, input string tag);
    logic [7:0] tgt, fin, lagB;
    int expReads, expSt, d0, e0, wait_c;
    logic [7:0] expRes;
    tgt = er ? 8'hFF : ex;
    fin = prot ? (tgt ^ 8'($urandom_range(1, 255))) : tgt;
    seq[0] = 8'h00;
    for (int i = 1; i < 64; i++) begin
      if (i <= nBusy) begin
        seq[i] = 8'($urandom);
        seq[i][7] = er ? 1'b0 : ~ex[7];
        seq[i][6] = i[0];
      end else if (i == nBusy + 1) begin
        lagB = 8'($urandom);
        lagB[7] = fin[7];
        lagB[6] = fin[6];
        seq[i] = lagB;
      end else begin
        seq[i] = fin;
      end
    end
    predict(tgl, er, ex, maxp, expReads, expSt, expRes);
    @(negedge clk);
    rdBase = readIdx;
    e0 = strobeErr;
    d0 = doneCnt;
    expAddr = ADDR_W'($urandom);
    pollAddr = expAddr; opErase = er; useToggle = tgl; expData = ex;
    maxPolls = CNT_W'(maxp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (2) @(negedge clk);
      check(busy == 1'b1, "R3", {tag, " busy during run"}, busy, 1);
      pollAddr = ~expAddr; opErase = ~er; useToggle = ~tgl; expData = ~ex;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_c = 0;
    while (doneCnt == d0 && wait_c < 2000) begin
      @(negedge clk);
      wait_c++;
    end
    repeat (12) @(negedge clk);
    check(doneCnt == d0 + 1, "R10", {tag, " done count"}, doneCnt - d0, 1);
    check(lastStatus == 2'(expSt), "R8", {tag, " status"}, lastStatus, expSt);
    check(lastResult == expRes, "R7", {tag, " result"}, lastResult, expRes);
    check(readIdx - rdBase == expReads, "R9", {tag, " read count"},
          readIdx - rdBase, expReads);
    check(strobeErr == e0, "R2", {tag, " strobe shape"}, strobeErr - e0, 0);
    check(status == 2'(expSt) && resultData == expRes, "R10", {tag, " held"},
          status, expSt);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) seq[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(flashCeN && flashOeN && !busy && !donePulse && status == 2'd0,
          "R1", "in reset", {flashCeN, flashOeN, busy, donePulse}, 4'b1100);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(flashCeN && flashOeN && !busy && !donePulse && status == 2'd0,
          "R1", "after reset", {flashCeN, flashOeN, busy, donePulse}, 4'b1100);

    runOp(1'b0, 1'b0, 8'hA5, 20, 5, 1'b0, 1'b0, "R4 prog data");
    runOp(1'b0, 1'b0, 8'h3C, 20, 3, 1'b0, 1'b0, "R4 prog data bit7 0");
    runOp(1'b0, 1'b1, 8'h00, 20, 7, 1'b0, 1'b0, "R5 erase data");
    runOp(1'b1, 1'b0, 8'h5A, 20, 6, 1'b0, 1'b0, "R6 prog toggle");
    runOp(1'b1, 1'b0, 8'h96, 20, 4, 1'b1, 1'b0, "R8 prog toggle prot");
    runOp(1'b1, 1'b1, 8'h00, 20, 5, 1'b1, 1'b0, "R8 erase toggle prot");
    runOp(1'b0, 1'b0, 8'h81, 4, 10, 1'b0, 1'b0, "R9 timeout data");
    runOp(1'b0, 1'b0, 8'h81, 0, 0, 1'b0, 1'b0, "R9 max zero hit");
    runOp(1'b0, 1'b1, 8'h00, 0, 3, 1'b0, 1'b0, "R9 max zero timeout");
    runOp(1'b1, 1'b0, 8'h11, 1, 0, 1'b0, 1'b0, "R6 toggle single read");
    runOp(1'b1, 1'b1, 8'h00, 20, 0, 1'b0, 1'b0, "R6 toggle no busy");
    runOp(1'b0, 1'b0, 8'hC3, 20, 6, 1'b0, 1'b1, "R3 start ignored");

    for (int n = 0; n < 40; n++) begin
      runOp(1'($urandom), 1'($urandom), 8'($urandom), $urandom_range(0, 30),
            $urandom_range(0, 20), ($urandom_range(0, 3) == 0),
            ($urandom_range(0, 3) == 0), "R7 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule